// File: doc/BRIEF.md
# Eight-Input Prioritized Interrupt Controller

This block collects eight interrupt request lines for a single CPU interrupt pin. A request register keeps the pending requests. A mask register blocks single inputs. An in-service register records the interrupts the CPU is currently handling. A fixed-priority resolver picks the most urgent unmasked pending request. It raises `int_req` only when that request outranks everything already in service, so a handler can be interrupted only by a more urgent input.

The CPU acknowledges with a one-cycle `inta` strobe. On that strobe the winning request moves from pending to in-service, and the block returns a vector equal to a programmable base plus the input number times a spacing of 4 or 8. Each input can be set to level or edge triggering. The CPU ends a handler with an end-of-interrupt command, or sets an automatic mode in which an acknowledged interrupt never enters service. All three registers can be read back through a select input.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset: mask register all ones, request and in-service registers zero, `int_req` low, `vec_out` zero, all inputs level-triggered, base 0, spacing 4, automatic end-of-interrupt off.
- R2: A mask bit of 1 (write address 0, bit i for input i) keeps request bit i at zero. Masking one input never blocks requests on other inputs, including lower-priority ones.
- R3: For a level-triggered input (trigger bit 0), the request bit equals the input ANDed with its inverted mask bit, registered one clock later.
- R4: For an edge-triggered input (write address 1, bit i = 1), a low-to-high change of the unmasked input sets the request bit. The bit stays set after the input falls and clears when that input is acknowledged or masked. An input held high through reset counts as no edge.
- R5: Input 0 has the highest priority and input 7 the lowest. `int_req` is high exactly when some request bit is set and the lowest set request index is below the lowest set in-service index, or no in-service bit is set.
- R6: An `inta` strobe while `int_req` is high sets the in-service bit of the winning input at the next clock. At the same clock `vec_out` becomes base + index × spacing, modulo 256.
- R7: An `inta` strobe while `int_req` is low leaves the in-service register unchanged and sets `vec_out` to base + 7 × spacing.
- R8: The vector base is written at address 2. Control bit 0 at address 3 selects a spacing of 8 when 1 and 4 when 0.
- R9: Any write to address 4 clears the lowest-index set bit of the in-service register. With no bit set it changes nothing.
- R10: With control bit 1 at address 3 set, an acknowledge returns its vector and clears an edge request but does not set the in-service bit.
- R11: `rd_sel` 0 returns the request register, 1 the in-service register, 2 the mask register and 3 zero, all combinationally.
- R12: Writes to addresses 5 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 8 | Interrupt request lines |
| inta | input | 1 | One-cycle acknowledge strobe from the CPU |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Status register select |
| rd_data | output | 8 | Selected status register |
| int_req | output | 1 | Interrupt request to the CPU |
| vec_out | output | 8 | Vector of the last acknowledge |

## Verification
Directed sequences cover four cases. Nesting (a lower input in service, then a higher and a lower request arrive) shows the priority gate works against the in-service register and not only among pending bits. Level and edge inputs that pulse, stay high or fall before the acknowledge show the two trigger modes apart. Acknowledges with nothing pending tell the spurious vector from a real one. Seeded random traffic then mixes masks, trigger modes, spacings, automatic end-of-interrupt and end-of-interrupt commands, and every cycle is compared with a reference model.

// File: rtl/irq_ctrl_pkg.sv
`timescale 1ns/1ps
package irq_ctrl_pkg;
    localparam int NUM_IRQ = 8;
    localparam int DATA_W  = 8;

    typedef enum logic [2:0] {
        ADDR_MASK = 3'd0,
        ADDR_TRIG = 3'd1,
        ADDR_BASE = 3'd2,
        ADDR_CTRL = 3'd3,
        ADDR_EOI  = 3'd4
    } reg_addr_e;

    localparam logic [1:0] SEL_IRR = 2'd0;
    localparam logic [1:0] SEL_ISR = 2'd1;
    localparam logic [1:0] SEL_IMR = 2'd2;
endpackage

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // lowest set index wins
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
    assign found = |vec;
endmodule

// File: rtl/irq_req_reg.sv
`timescale 1ns/1ps
module irq_req_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] edge_mode,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] irr_q
);
    typedef struct packed {
        logic [N-1:0] irr;
        logic [N-1:0] prev;
    } req_st_t;

    req_st_t r_d, r_q;
    logic [N-1:0] rise;

    always_comb begin
        r_d      = r_q;
        rise     = irq & ~r_q.prev;
        r_d.prev = irq;
        for (int i = 0; i < N; i++) begin
            if (mask[i])
                r_d.irr[i] = 1'b0;
            else if (edge_mode[i])
                r_d.irr[i] = (r_q.irr[i] & ~ack_clr[i]) | rise[i];
            else
                r_d.irr[i] = irq[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.irr  <= '0;
            r_q.prev <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign irr_q = r_q.irr;

    assert_mask_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.irr & $past(mask)) == '0));

    assert_edge_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(r_q.irr & edge_mode & ~mask & ~ack_clr) & ~r_q.irr) == '0));
endmodule

// File: rtl/irq_ctrl8.sv
`timescale 1ns/1ps
module irq_ctrl8 import irq_ctrl_pkg::*; #(
    parameter int N  = NUM_IRQ,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq,
    input  logic          inta,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    rd_sel,
    output logic [DW-1:0] rd_data,
    output logic          int_req,
    output logic [DW-1:0] vec_out
);
    localparam int IDX_W = $clog2(N);

    typedef struct packed {
        logic [N-1:0]  imr;
        logic [N-1:0]  trig;
        logic [N-1:0]  isr;
        logic [DW-1:0] base;
        logic [DW-1:0] vec;
        logic          sp8;
        logic          aeoi;
    } ctl_st_t;

    ctl_st_t s_d, s_q;

    logic [N-1:0]     irr_q;
    logic [N-1:0]     ack_clr;
    logic             irr_found, isr_found;
    logic [IDX_W-1:0] irr_idx, isr_idx;
    logic             ack_ok, eoi;
    logic [IDX_W-1:0] vec_idx;

    irq_req_reg #(.N(N)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq      (irq),
        .mask     (s_q.imr),
        .edge_mode(s_q.trig),
        .ack_clr  (ack_clr),
        .irr_q    (irr_q)
    );

    irq_prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick_irr (
        .vec(irr_q), .found(irr_found), .idx(irr_idx)
    );

    irq_prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick_isr (
        .vec(s_q.isr), .found(isr_found), .idx(isr_idx)
    );

    assign int_req = irr_found && (!isr_found || (irr_idx < isr_idx));
    assign ack_ok  = inta && int_req;
    assign eoi     = wr_en && (wr_addr == ADDR_EOI);
    assign ack_clr = ack_ok ? (N'(1) << irr_idx) : '0;
    assign vec_idx = ack_ok ? irr_idx : IDX_W'(N - 1);

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_MASK: s_d.imr  = wr_data[N-1:0];
                ADDR_TRIG: s_d.trig = wr_data[N-1:0];
                ADDR_BASE: s_d.base = wr_data;
                ADDR_CTRL: begin
                    s_d.sp8  = wr_data[0];
                    s_d.aeoi = wr_data[1];
                end
                default: ;
            endcase
        end
        if (eoi && isr_found) s_d.isr[isr_idx] = 1'b0;
        if (ack_ok && !s_q.aeoi) s_d.isr[irr_idx] = 1'b1;
        if (inta) s_d.vec = s_q.base + (DW'(vec_idx) << (s_q.sp8 ? 3 : 2));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.imr  <= '1;
            s_q.trig <= '0;
            s_q.isr  <= '0;
            s_q.base <= '0;
            s_q.vec  <= '0;
            s_q.sp8  <= 1'b0;
            s_q.aeoi <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (rd_sel)
            SEL_IRR: rd_data = DW'(irr_q);
            SEL_ISR: rd_data = DW'(s_q.isr);
            SEL_IMR: rd_data = DW'(s_q.imr);
            default: rd_data = '0;
        endcase
    end

    assign vec_out = s_q.vec;

    assert_int_has_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (irr_q != '0));

    assert_ack_enters_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && int_req && !s_q.aeoi && !eoi) |=>
        ($countones(s_q.isr) == $countones($past(s_q.isr)) + 1));

    assert_spurious_keeps_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !int_req && !eoi) |=> $stable(s_q.isr));

    assert_eoi_clears_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !inta && (s_q.isr != '0)) |=>
        ($countones(s_q.isr) == $countones($past(s_q.isr)) - 1));

    assert_auto_eoi_no_service_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && s_q.aeoi && !eoi) |=> $stable(s_q.isr));
endmodule

// File: tb/tb_irq_ctrl8.sv
`timescale 1ns/1ps
module tb_irq_ctrl8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq = '0;
    logic       inta = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic       int_req;
    logic [7:0] vec_out;

    int n_checks = 0;
    int n_fails  = 0;

    // reference state
    logic [7:0] m_irr, m_isr, m_imr, m_trig, m_base, m_vec, m_prev;
    logic       m_sp8, m_aeoi;

    always #2.5 clk = ~clk;

    irq_ctrl8 dut (
        .clk(clk), .rst_n(rst_n), .irq(irq), .inta(inta),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .int_req(int_req), .vec_out(vec_out)
    );

    function automatic int lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic logic exp_int(input logic [7:0] irr, input logic [7:0] isr);
        if (irr == 0) return 1'b0;
        return lowest(irr) < lowest(isr);
    endfunction

    function automatic logic [7:0] exp_vec(input logic [7:0] base, input int idx, input logic sp8);
        return 8'(base + 8'(idx * (sp8 ? 8 : 4)));
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_irr = 0; m_isr = 0; m_imr = 8'hFF; m_trig = 0; m_base = 0;
        m_vec = 0; m_prev = 8'hFF; m_sp8 = 0; m_aeoi = 0;
    endtask

    task automatic compare_all();
        check("R5 int_req", {7'd0, int_req}, {7'd0, exp_int(m_irr, m_isr)});
        check("R6 R7 R8 vec_out", vec_out, m_vec);
        rd_sel = 2'd0; #0.3;
        check("R2 R3 R4 R11 irr", rd_data, m_irr);
        rd_sel = 2'd1; #0.3;
        check("R9 R10 R11 isr", rd_data, m_isr);
        rd_sel = 2'd2; #0.3;
        check("R11 R12 imr", rd_data, m_imr);
    endtask

    // one clock: drive at negedge, advance model, compare at next negedge
    task automatic cyc(input logic [7:0] i_irq, input logic i_ack,
                       input logic i_we, input logic [2:0] i_addr, input logic [7:0] i_data);
        logic [7:0] n_irr, n_isr, rise;
        logic       ok;
        int         w;
        irq = i_irq; inta = i_ack; wr_en = i_we; wr_addr = i_addr; wr_data = i_data;
        ok   = i_ack && exp_int(m_irr, m_isr);
        w    = lowest(m_irr);
        rise = i_irq & ~m_prev;
        n_isr = m_isr;
        for (int i = 0; i < 8; i++) begin
            if (m_imr[i]) n_irr[i] = 1'b0;
            else if (m_trig[i]) n_irr[i] = (m_irr[i] && !(ok && w == i)) || rise[i];
            else n_irr[i] = i_irq[i];
        end
        if (i_we && i_addr == 3'd4 && m_isr != 0) n_isr[lowest(m_isr)] = 1'b0;
        if (ok && !m_aeoi) n_isr[w] = 1'b1;
        if (i_ack) m_vec = exp_vec(m_base, ok ? w : 7, m_sp8);
        if (i_we) begin
            case (i_addr)
                3'd0: m_imr = i_data;
                3'd1: m_trig = i_data;
                3'd2: m_base = i_data;
                3'd3: begin m_sp8 = i_data[0]; m_aeoi = i_data[1]; end
                default: ;
            endcase
        end
        m_irr = n_irr; m_isr = n_isr; m_prev = i_irq;
        @(posedge clk);
        @(negedge clk);
        inta = 1'b0; wr_en = 1'b0;
        compare_all();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic [7:0] i_irq);
        cyc(i_irq, 1'b0, 1'b1, a, d);
    endtask

    initial begin
        #1000000;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        model_reset();
        irq = 8'hA5;                 // held high through reset: no edge later (R4)
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 int_req", {7'd0, int_req}, 8'd0);
        check("R1 vec_out", vec_out, 8'd0);
        rd_sel = 2'd2; #0.3; check("R1 imr", rd_data, 8'hFF);
        rd_sel = 2'd0; #0.3; check("R1 irr", rd_data, 8'h00);
        rd_sel = 2'd1; #0.3; check("R1 isr", rd_data, 8'h00);
        rd_sel = 2'd3; #0.3; check("R11 sel3 zero", rd_data, 8'h00);

        // R7 spurious acknowledge with everything masked
        cyc(8'h00, 1'b1, 1'b0, 3'd0, 8'h00);
        check("R7 spurious vector", vec_out, 8'd28);

        // R12 writes to unused addresses
        wr(3'd5, 8'h00, 8'h00); wr(3'd6, 8'h00, 8'h00); wr(3'd7, 8'h00, 8'h00);
        rd_sel = 2'd2; #0.3; check("R12 imr unchanged", rd_data, 8'hFF);

        // R3 level, R8 base, R2 masking higher keeps lower
        wr(3'd2, 8'h40, 8'h00);
        wr(3'd0, 8'h01, 8'h00);
        cyc(8'h03, 1'b0, 1'b0, 3'd0, 8'h00);
        rd_sel = 2'd0; #0.3; check("R2 lower not blocked", rd_data, 8'h02);
        wr(3'd0, 8'h00, 8'h00);

        // R6 nesting: input 5 in service, input 2 interrupts, input 6 does not
        cyc(8'h20, 1'b0, 1'b0, 3'd0, 8'h00);
        cyc(8'h20, 1'b1, 1'b0, 3'd0, 8'h00);
        check("R6 vector input5", vec_out, 8'h54);
        cyc(8'h60, 1'b0, 1'b0, 3'd0, 8'h00);
        check("R5 lower blocked by service", {7'd0, int_req}, 8'd0);
        cyc(8'h64, 1'b0, 1'b0, 3'd0, 8'h00);
        check("R5 higher preempts", {7'd0, int_req}, 8'd1);
        cyc(8'h64, 1'b1, 1'b0, 3'd0, 8'h00);
        rd_sel = 2'd1; #0.3; check("R6 nested isr", rd_data, 8'h24);
        wr(3'd4, 8'h00, 8'h00);
        rd_sel = 2'd1; #0.3; check("R9 clears highest", rd_data, 8'h20);
        wr(3'd4, 8'h00, 8'h00);
        wr(3'd4, 8'h00, 8'h00);
        rd_sel = 2'd1; #0.3; check("R9 empty no change", rd_data, 8'h00);

        // R4 edge mode, R8 spacing 8
        wr(3'd1, 8'hFF, 8'h00);
        wr(3'd3, 8'h01, 8'h00);
        cyc(8'h08, 1'b0, 1'b0, 3'd0, 8'h00);
        cyc(8'h00, 1'b0, 1'b0, 3'd0, 8'h00);
        rd_sel = 2'd0; #0.3; check("R4 edge held", rd_data, 8'h08);
        cyc(8'h00, 1'b1, 1'b0, 3'd0, 8'h00);
        check("R8 spacing 8", vec_out, 8'h58);
        rd_sel = 2'd0; #0.3; check("R4 cleared by ack", rd_data, 8'h00);
        wr(3'd4, 8'h00, 8'h00);

        // R10 automatic end of interrupt
        wr(3'd3, 8'h02, 8'h00);
        cyc(8'h10, 1'b0, 1'b0, 3'd0, 8'h00);
        cyc(8'h10, 1'b1, 1'b0, 3'd0, 8'h00);
        rd_sel = 2'd1; #0.3; check("R10 no service bit", rd_data, 8'h00);
        check("R10 vector", vec_out, 8'h50);

        // seeded random traffic
        begin
            int seed_dummy;
            seed_dummy = $urandom(32'h1F2E3D4C);
        end
        for (int k = 0; k < 4000; k++) begin
            int r;
            logic [7:0] ri;
            r  = $urandom_range(0, 99);
            ri = 8'($urandom);
            if (r < 15)      cyc(ri, 1'b1, 1'b0, 3'd0, 8'h00);
            else if (r < 25) cyc(ri, 1'b0, 1'b1, 3'd4, 8'h00);
            else if (r < 27) cyc(ri, 1'b0, 1'b1, 3'd0, 8'($urandom) & 8'($urandom));
            else if (r < 29) cyc(ri, 1'b0, 1'b1, 3'd1, 8'($urandom));
            else if (r < 30) cyc(ri, 1'b0, 1'b1, 3'd2, 8'($urandom));
            else if (r < 31) cyc(ri, 1'b0, 1'b1, 3'd3, 8'($urandom));
            else if (r < 32) cyc(ri, 1'b1, 1'b1, 3'd4, 8'h00);
            else if (r < 33) cyc(ri, 1'b0, 1'b1, 3'($urandom_range(5, 7)), 8'($urandom));
            else             cyc(ri, 1'b0, 1'b0, 3'd0, 8'h00);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule